// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is a single comparator channel for a multi-channel event timer. It watches a free-running main counter that is supplied from outside and raises a one-clock fire pulse toward the interrupt logic when the counter reaches a programmed comparator value. The channel can run one-shot or periodic. In periodic mode the comparator is moved forward by a stored period after each match. A narrow mode restricts the comparison, the comparator and the period to the low 32 bits.

Software programs the channel through three write strobes: a 4-bit configuration word and the low and high 32-bit halves of the comparator word. In periodic mode a comparator write goes to the period. It also reaches the comparator when the one-time load bit in the configuration is set, and that bit clears itself after the write. In narrow one-shot mode a comparator value that lies behind the counter first produces an event when the counter's low half reaches all ones. The real match follows later. The configuration, comparator and period registers are visible on output ports so that the surrounding register file can read them back.

Top module: `evt_cmp_channel`

## Requirements
- R1: After reset the comparator reads all ones, the period reads 0, the configuration reads 0 and no fire pulse is produced.
- R2: The configuration word is stored as written and read back on `cfg_o`. Bit 0 is the channel enable, bit 1 selects periodic mode, bit 2 selects narrow 32-bit mode and bit 3 is the one-time comparator load bit.
- R3: The comparator is written in two 32-bit halves. The low strobe writes bits 31:0 and the high strobe writes bits 63:32. A write to one half leaves the other half unchanged. In one-shot mode either write loads the comparator.
- R4: In periodic mode a comparator write always loads the same half of the period. It loads the comparator as well only when the load bit is 1. Any comparator write clears the load bit.
- R5: A value written to the period has its top bit forced to 0. That is bit 31 of the low half in narrow mode, and bit 31 of the high half (bit 63) in wide mode.
- R6: Writing a configuration word with the narrow bit set clears the upper 32 bits of the comparator and of the period. While narrow mode is active, high-half writes change neither register.
- R7: The counter has reached the comparator when (comparator − counter) is zero or negative, taken as a signed 64-bit value in wide mode and as a signed 32-bit value of the low halves in narrow mode. An armed, enabled channel with the global enable set pulses `fire_o` for one cycle, in the same cycle the counter first reaches the comparator.
- R8: In one-shot mode a match disarms the channel. It does not fire again until it is re-armed.
- R9: In periodic mode with a non-zero period, a match adds the period to the comparator. The addition is modulo 2^32 in narrow mode. The channel keeps adding the period, once per cycle and without further pulses, until the comparator is again ahead of the counter.
- R10: When a narrow one-shot channel is armed with a comparator that is not yet reached and whose low half is below the counter's low half, it fires once when the counter's low half equals 0xFFFFFFFF. It then fires again at the real match.
- R11: A 0-to-1 change of the channel enable arms the channel only while the global enable is 1. A comparator write made while the global enable is 1 re-arms the channel.
- R12: A 1-to-0 change of the channel enable disarms the channel and pulses `clr_o` in the cycle of the write. No fire pulse follows.
- R13: With the global enable at 0 the channel never fires and its comparator does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| count_i | input | 64 | Main counter value |
| glb_en_i | input | 1 | Global enable of the timer block |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 4 | Configuration word: enable, periodic, narrow, load |
| cmp_lo_we_i | input | 1 | Comparator low-half write strobe |
| cmp_hi_we_i | input | 1 | Comparator high-half write strobe |
| cmp_wdata_i | input | 32 | Comparator write data |
| fire_o | output | 1 | One-cycle event pulse to the interrupt logic |
| clr_o | output | 1 | Request to clear this channel's interrupt on disable |
| cfg_o | output | 4 | Stored configuration word |
| cmp_o | output | 64 | Current comparator |
| per_o | output | 64 | Current period |

## Verification
The assertions assume that only one write strobe is active in any cycle. They also assume that the counter advances forward, so the single-pulse property is checked only in cycles with no write, and the disarm property only when no comparator write re-arms the channel. Because the wrap event compares the low half against all ones, the bench steps the counter one count at a time across that value. Elsewhere it may jump, to exercise the catch-up addition. The random part of the stimulus keeps the global enable low. This confines it to register decoding, where the bench model for writes is exact, while the firing behaviour is covered by directed sequences.

// File: rtl/evt_cmp_channel.sv
module evt_cmp_channel #(
  parameter int HW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2*HW-1:0] count_i,
  input  logic            glb_en_i,
  input  logic            cfg_we_i,
  input  logic [3:0]      cfg_wdata_i,
  input  logic            cmp_lo_we_i,
  input  logic            cmp_hi_we_i,
  input  logic [HW-1:0]   cmp_wdata_i,
  output logic            fire_o,
  output logic            clr_o,
  output logic [3:0]      cfg_o,
  output logic [2*HW-1:0] cmp_o,
  output logic [2*HW-1:0] per_o
);
  localparam int CW    = 2 * HW;
  localparam int B_EN  = 0;
  localparam int B_PER = 1;
  localparam int B_W32 = 2;
  localparam int B_SV  = 3;

  logic [3:0]    cfg_q, cfg_n;
  logic [CW-1:0] cmp_q, cmp_n, per_q, per_n, sum;
  logic          armed_q, armed_n, chase_q, chase_n, wrap_q, wrap_n;
  logic          eligible, reached, wrap_hit, arm;

  function automatic logic hit(input logic narrow, input logic [CW-1:0] c, input logic [CW-1:0] n);
    logic [CW-1:0] d;
    d = c - n;
    return narrow ? (d[HW-1] || d[HW-1:0] == '0) : (d[CW-1] || d == '0);
  endfunction

  assign eligible = armed_q && cfg_q[B_EN] && glb_en_i;
  assign reached  = hit(cfg_q[B_W32], cmp_q, count_i);
  assign wrap_hit = cfg_q[B_W32] && !cfg_q[B_PER] && (count_i[HW-1:0] == '1);
  assign sum      = cfg_q[B_W32] ? {{HW{1'b0}}, cmp_q[HW-1:0] + per_q[HW-1:0]} : cmp_q + per_q;

  assign fire_o = eligible && (wrap_q ? wrap_hit : (reached && !chase_q));
  assign clr_o  = cfg_we_i && cfg_q[B_EN] && !cfg_wdata_i[B_EN];
  assign cfg_o  = cfg_q;
  assign cmp_o  = cmp_q;
  assign per_o  = per_q;

  always_comb begin
    logic pm, sv, nw;
    cfg_n   = cfg_q;
    cmp_n   = cmp_q;
    per_n   = per_q;
    armed_n = armed_q;
    chase_n = chase_q;
    wrap_n  = wrap_q;
    arm     = 1'b0;

    if (!eligible) begin
      chase_n = 1'b0;
    end else if (wrap_q) begin
      if (wrap_hit) wrap_n = 1'b0;
    end else if (chase_q) begin
      if (reached) cmp_n = sum;
      else         chase_n = 1'b0;
    end else if (reached) begin
      if (cfg_q[B_PER] && per_q != '0) begin
        cmp_n   = sum;
        chase_n = 1'b1;
      end else begin
        armed_n = 1'b0;
      end
    end

    if (cfg_we_i) begin
      cfg_n = cfg_wdata_i;
      if (cfg_wdata_i[B_W32]) begin
        cmp_n[CW-1:HW] = '0;
        per_n[CW-1:HW] = '0;
      end
      if (cfg_wdata_i[B_EN] && !cfg_q[B_EN] && glb_en_i) arm = 1'b1;
      if (!cfg_wdata_i[B_EN] && cfg_q[B_EN]) begin
        armed_n = 1'b0;
        chase_n = 1'b0;
        wrap_n  = 1'b0;
      end
    end

    pm = cfg_n[B_PER];
    sv = cfg_n[B_SV];
    nw = cfg_n[B_W32];
    if (cmp_lo_we_i) begin
      if (!pm || sv) cmp_n[HW-1:0] = cmp_wdata_i;
      if (pm)        per_n[HW-1:0] = nw ? {1'b0, cmp_wdata_i[HW-2:0]} : cmp_wdata_i;
    end
    if (cmp_hi_we_i && !nw) begin
      if (!pm || sv) cmp_n[CW-1:HW] = cmp_wdata_i;
      if (pm)        per_n[CW-1:HW] = {1'b0, cmp_wdata_i[HW-2:0]};
    end
    if (cmp_lo_we_i || cmp_hi_we_i) begin
      cfg_n[B_SV] = 1'b0;
      if (glb_en_i) arm = 1'b1;
    end

    if (arm) begin
      armed_n = 1'b1;
      chase_n = 1'b0;
      wrap_n  = nw && !pm && !hit(nw, cmp_n, count_i) &&
                (cmp_n[HW-1:0] < count_i[HW-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      cmp_q   <= '1;
      per_q   <= '0;
      armed_q <= 1'b0;
      chase_q <= 1'b0;
      wrap_q  <= 1'b0;
    end else begin
      cfg_q   <= cfg_n;
      cmp_q   <= cmp_n;
      per_q   <= per_n;
      armed_q <= armed_n;
      chase_q <= chase_n;
      wrap_q  <= wrap_n;
    end
  end

  // R7
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_o && !wrap_q && !cfg_we_i && !cmp_lo_we_i && !cmp_hi_we_i) |=> !fire_o);

  // R12
  disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_o && !cmp_lo_we_i && !cmp_hi_we_i) |=> !fire_o);

  // R13
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_en_i && !cfg_we_i && !cmp_lo_we_i && !cmp_hi_we_i) |=> ($stable(cmp_o) && $stable(per_o)));

  // R5
  per_top_chk: assert property (@(posedge clk) disable iff (!rst_n) !per_o[CW-1]);

  // R6
  narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_o[B_W32] |-> (cmp_o[CW-1:HW] == '0 && per_o[CW-1:HW] == '0));

endmodule

// File: tb/evt_cmp_channel_test.sv
module evt_cmp_channel_test;
  localparam int HW = 32;
  localparam int CW = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [CW-1:0] count = '0;
  logic          glb = 1'b0;
  logic          cfg_we = 1'b0;
  logic [3:0]    cfg_wd = '0;
  logic          lo_we = 1'b0;
  logic          hi_we = 1'b0;
  logic [HW-1:0] wd = '0;
  logic          fire, clr;
  logic [3:0]    cfg_o;
  logic [CW-1:0] cmp_o, per_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [3:0]    m_cfg = '0;
  logic [CW-1:0] m_cmp = '1;
  logic [CW-1:0] m_per = '0;

  evt_cmp_channel #(.HW(HW)) uut (
    .clk(clk), .rst_n(rst_n), .count_i(count), .glb_en_i(glb),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wd),
    .cmp_lo_we_i(lo_we), .cmp_hi_we_i(hi_we), .cmp_wdata_i(wd),
    .fire_o(fire), .clr_o(clr), .cfg_o(cfg_o), .cmp_o(cmp_o), .per_o(per_o)
  );

  task automatic chk(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic nxt();
    @(posedge clk); #1;
    cfg_we = 1'b0; lo_we = 1'b0; hi_we = 1'b0;
  endtask

  task automatic m_lo(input logic [HW-1:0] d);
    if (!m_cfg[1] || m_cfg[3]) m_cmp[HW-1:0] = d;
    if (m_cfg[1]) m_per[HW-1:0] = m_cfg[2] ? {1'b0, d[HW-2:0]} : d;
    m_cfg[3] = 1'b0;
  endtask

  task automatic m_hi(input logic [HW-1:0] d);
    if (!m_cfg[2]) begin
      if (!m_cfg[1] || m_cfg[3]) m_cmp[CW-1:HW] = d;
      if (m_cfg[1]) m_per[CW-1:HW] = {1'b0, d[HW-2:0]};
    end
    m_cfg[3] = 1'b0;
  endtask

  task automatic wcfg(input logic [3:0] v);
    logic e;
    e = m_cfg[0] && !v[0];
    cfg_we = 1'b1; cfg_wd = v;
    @(negedge clk);
    chk("R12 clear pulse on write", CW'(clr), CW'(e));
    nxt();
    m_cfg = v;
    if (v[2]) begin m_cmp[CW-1:HW] = '0; m_per[CW-1:HW] = '0; end
  endtask

  task automatic wlo(input logic [HW-1:0] d);
    lo_we = 1'b1; wd = d;
    nxt();
    m_lo(d);
  endtask

  task automatic whi(input logic [HW-1:0] d);
    hi_we = 1'b1; wd = d;
    nxt();
    m_hi(d);
  endtask

  task automatic state(input string req);
    chk({req, " comparator"}, cmp_o, m_cmp);
    chk({req, " period"}, per_o, m_per);
    chk({req, " config"}, CW'(cfg_o), CW'(m_cfg));
  endtask

  task automatic run(input logic [CW-1:0] c, input logic e, input string req);
    count = c;
    @(negedge clk);
    chk(req, CW'(fire), CW'(e));
    nxt();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5eed);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset fire", CW'(fire), '0);
    #1 rst_n = 1'b1;
    nxt();
    state("R1 reset");

    // R3, R11, R7, R8, R13: one-shot wide mode
    count = 64'd100;
    wlo(32'd110);
    chk("R3 low half only", cmp_o, 64'hFFFF_FFFF_0000_006E);
    whi(32'd0);
    chk("R3 high half", cmp_o, 64'd110);
    wcfg(4'b0001);
    chk("R2 config readback", CW'(cfg_o), 64'h1);
    for (int c = 105; c <= 120; c++) run(CW'(c), 1'b0, "R13 no fire global off");
    glb = 1'b1;
    run(64'd121, 1'b0, "R11 enable without global does not arm");
    wlo(32'd150);
    for (int c = 140; c <= 160; c++)
      run(CW'(c), c == 150, (c <= 150) ? "R7 one-shot match" : "R8 one-shot after match");
    wlo(32'd170);
    glb = 1'b0;
    for (int c = 165; c <= 175; c++) run(CW'(c), 1'b0, "R13 gated by global enable");
    chk("R13 comparator held", cmp_o, 64'd170);
    glb = 1'b1;
    run(64'd176, 1'b1, "R13 fire when global enable returns");
    run(64'd177, 1'b0, "R8 disarmed after fire");

    // R4, R9: periodic wide mode
    wcfg(4'b1010);
    wlo(32'd200);
    chk("R4 load bit loads comparator", cmp_o, 64'd200);
    chk("R4 load bit cleared", CW'(cfg_o), 64'h2);
    wlo(32'd10);
    state("R4 period only");
    chk("R4 comparator kept", cmp_o, 64'd200);
    count = 64'd195;
    wcfg(4'b0011);
    for (int c = 196; c <= 235; c++)
      run(CW'(c), (c >= 200) && (c % 10 == 0), "R9 periodic match");
    run(64'd265, 1'b1, "R9 catch-up first pulse");
    run(64'd265, 1'b0, "R9 catch-up silent");
    run(64'd265, 1'b0, "R9 catch-up silent");
    run(64'd265, 1'b0, "R9 catch-up silent");
    chk("R9 comparator ahead after catch-up", cmp_o, 64'd270);
    run(64'd270, 1'b1, "R9 match after catch-up");
    m_cmp = 64'd280;

    // R12: disable
    count = 64'd271;
    wcfg(4'b0010);
    count = 64'd280;
    @(negedge clk);
    chk("R12 no fire after disable", CW'(fire), '0);
    chk("R12 clear pulse one cycle", CW'(clr), '0);
    nxt();

    // R5, R6, R10: narrow mode
    glb = 1'b0;
    whi(32'h8000_0001);
    chk("R5 period top bit forced", per_o, 64'h0000_0001_0000_000A);
    wcfg(4'b0000);
    wlo(32'h55);
    whi(32'h1234);
    chk("R3 both halves", cmp_o, 64'h0000_1234_0000_0055);
    wcfg(4'b0100);
    chk("R6 comparator truncated", cmp_o, 64'h55);
    chk("R6 period truncated", per_o, 64'd10);
    whi(32'hABCD);
    chk("R6 high write ignored", cmp_o, 64'h55);
    count = 64'h7_FFFF_FFF0;
    glb = 1'b1;
    wcfg(4'b0101);
    for (int i = 1; i <= 16 + 32'h60; i++) begin
      logic [CW-1:0] c;
      c = 64'h7_FFFF_FFF0 + CW'(i);
      run(c, (c[HW-1:0] == 32'hFFFF_FFFF) || (c[HW-1:0] == 32'h55), "R10 wrap then match");
    end

    // R2-R6, R12, R13: random register traffic with global enable off
    glb = 1'b0;
    m_cfg = 4'b0101; m_cmp = 64'h55; m_per = 64'd10;
    for (int k = 0; k < 400; k++) begin
      int unsigned op;
      logic [HW-1:0] d;
      op = $urandom % 3;
      d  = ($urandom % 4 == 0) ? 32'hFFFF_FFFF : HW'($urandom);
      count = {HW'($urandom), HW'($urandom)};
      if (op == 0) wcfg(4'($urandom));
      else if (op == 1) wlo(d);
      else whi(d);
      @(negedge clk);
      chk("R13 no fire during register traffic", CW'(fire), '0);
      state("R2 R4 R5 R6 random write");
      nxt();
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule